// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a single-channel watchdog timer behind a small word-addressed register interface. A free-running prescaler divides the input clock by a power of two, 1024 by default. Each prescaler tick lowers a down-counter by one. Software keeps the system alive by poking the timer. A poke reloads the counter from a programmable length field, which fills only the counter's upper bits. The lower bits are zero after every reload.

If the counter reaches zero and a further tick arrives, the timer expires. An expiry reloads the counter and moves an escalation stage forward. A two-bit mode decides what each stage does:

- In the lightest mode, every expiry raises a CPU interrupt.
- In the next mode, the second and later expiries flag an interrupt for a management processor.
- In the heaviest mode, the third expiry emits a one-cycle reset request. The timer then freezes until software rewrites the control word.

Each interrupt source has a pending bit, cleared by writing 1 to it. Enable bits are set and cleared through two separate addresses. An interrupt output is active only while its source is both pending and enabled. When the management interrupt is not enabled, the second expiry in the heaviest mode therefore has no visible effect.

Top module: `esc_wdog`

## Requirements
- R1: After reset the control word reads mode 0 in bits [1:0], length RST_LEN in bits [LEN_W+1:2], and count RST_LEN shifted left by CNT_W-LEN_W in bits [CNT_W+LEN_W+1:LEN_W+2]. The pending word (address 1) reads 0, the enable word (addresses 2 and 3) reads 0, and cpu_irq, mgmt_irq and rst_req are low.
- R2: While the mode is 0 (stopped), the count does not change and no expiry occurs.
- R3: While the mode is nonzero and the timer is not frozen, the count falls by exactly one every 2^PRESC_W clock cycles. By default this is every 1024 cycles.
- R4: A write to address 4 with data bit 0 set is a poke. A poke loads the count with the length in the upper LEN_W bits and zeros below, resets the escalation stage and restarts the prescaler phase. A write to address 4 with bit 0 clear has no effect.
- R5: A tick that finds the count at zero is an expiry. An expiry reloads the count from the length. A new length written to the control word (address 0) leaves the running count untouched and is used from the next reload.
- R6: In mode 1, every expiry sets the CPU pending bit (bit 0 of address 1).
- R7: In mode 2, the first expiry after a poke sets the CPU pending bit. Every later expiry sets the management pending bit (bit 1 of address 1).
- R8: In mode 3, the first expiry sets the CPU pending bit and the second sets the management pending bit. The third drives rst_req high for exactly one cycle and freezes the count. Any later write to the control word releases the freeze and restarts escalation at the first stage.
- R9: Writing 1 to a bit of address 1 clears that pending bit, and writing 0 leaves it unchanged. An expiry that sets a bit in the same cycle as a clear of that bit wins.
- R10: A write of 1 to a bit of address 2 sets that enable bit, and a write of 1 to a bit of address 3 clears it; bit 0 is the CPU source and bit 1 the management source. cpu_irq is high exactly when CPU pending and CPU enable are both set, and mgmt_irq likewise for bit 1.
- R11: Writing mode 0 to the control word clears the escalation stage and the prescaler phase.
- R12: A poke in the same cycle as an expiry wins. No pending bit is set, and the count reloads as for a poke.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for both write and read |
| reg_wdata | input | LEN_W+2 | Write data |
| reg_rdata | output | CNT_W+LEN_W+2 | Read data for reg_addr, combinational |
| cpu_irq | output | 1 | CPU interrupt, pending and enabled |
| mgmt_irq | output | 1 | Management-processor interrupt, pending and enabled |
| rst_req | output | 1 | One-cycle reset request on the final stage |

## Verification
Two events can land on the same clock edge: a software register write and a timer expiry. In one case a poke is the write. The bench times it to the exact edge on which the counter would expire and then expects no pending bit and a freshly loaded count. In the other case the write is a write-1 clear of the CPU pending bit, placed on the expiry edge, and the bench expects the bit to remain set. Both are judged from the edge counts that follow from the prescaler period and the reload value.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_CPU   = 2'd1,
    WD_MGMT  = 2'd2,
    WD_RESET = 2'd3
  } wd_mode_e;

  localparam int unsigned MODE_W = 2;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_PEND  = 3'd1;
  localparam logic [REG_AW-1:0] RA_ENSET = 3'd2;
  localparam logic [REG_AW-1:0] RA_ENCLR = 3'd3;
  localparam logic [REG_AW-1:0] RA_POKE  = 3'd4;

  typedef struct packed {
    logic rst;
    logic mgmt;
    logic cpu;
  } wd_evt_t;

endpackage

// File: rtl/esc_wdog_rst_sync.sv
module esc_wdog_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/esc_wdog_presc.sv
module esc_wdog_presc #(
  parameter int unsigned PRESC_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);

  localparam logic [PRESC_W-1:0] DIV_LAST = '1;
  localparam logic [PRESC_W-1:0] DIV_ONE  = PRESC_W'(1);

  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] div_d;

  always_comb begin
    div_d = div_q;
    if (clr)      div_d = '0;
    else if (run) div_d = div_q + DIV_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = run && !clr && (div_q == DIV_LAST);

  // R3: ticks are at least two cycles apart
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/esc_wdog_timer.sv
module esc_wdog_timer
  import esc_wdog_pkg::*;
#(
  parameter int unsigned      CNT_W   = 24,
  parameter int unsigned      LEN_W   = 16,
  parameter logic [LEN_W-1:0] RST_LEN = 16'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             poke,
  input  logic             ctrl_wr,
  input  wd_mode_e         wr_mode,
  input  wd_mode_e         mode,
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output wd_evt_t          evt
);

  localparam int unsigned      LOW_W   = CNT_W - LEN_W;
  localparam logic [CNT_W-1:0] CNT_RST = {RST_LEN, {LOW_W{1'b0}}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       stage_q, stage_d;
  logic             halt_q, halt_d;
  logic [CNT_W-1:0] reload;

  assign reload = {len, {LOW_W{1'b0}}};

  always_comb begin
    cnt_d   = cnt_q;
    stage_d = stage_q;
    halt_d  = halt_q;
    evt     = '0;
    if (poke) begin
      cnt_d   = reload;
      stage_d = 2'd0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d = reload;
        case (mode)
          WD_CPU: evt.cpu = 1'b1;
          WD_MGMT: begin
            if (stage_q == 2'd0) begin
              evt.cpu = 1'b1;
              stage_d = 2'd1;
            end else begin
              evt.mgmt = 1'b1;
            end
          end
          WD_RESET: begin
            case (stage_q)
              2'd0: begin
                evt.cpu = 1'b1;
                stage_d = 2'd1;
              end
              2'd1: begin
                evt.mgmt = 1'b1;
                stage_d  = 2'd2;
              end
              default: begin
                evt.rst = 1'b1;
                halt_d  = 1'b1;
              end
            endcase
          end
          default: ;
        endcase
      end else begin
        cnt_d = cnt_q - CNT_ONE;
      end
    end
    if (ctrl_wr) begin
      if (halt_q) begin
        halt_d  = 1'b0;
        stage_d = 2'd0;
      end
      if (wr_mode == WD_OFF) stage_d = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_RST;
      stage_q <= 2'd0;
      halt_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      halt_q  <= halt_d;
    end
  end

  assign count = cnt_q;
  assign run   = (mode != WD_OFF) && !halt_q;

  // R4: a poke loads the length into the upper bits and restarts the stage
  assert_poke_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poke |=> (cnt_q == $past(reload)) && (stage_q == 2'd0));

  // R2: a stopped timer holds its count
  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WD_OFF && !poke) |=> $stable(cnt_q));

  // R8: a frozen timer holds its count until released
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !ctrl_wr && !poke) |=> $stable(cnt_q));

endmodule

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
  import esc_wdog_pkg::*;
#(
  parameter int unsigned      CNT_W   = 24,
  parameter int unsigned      LEN_W   = 16,
  parameter logic [LEN_W-1:0] RST_LEN = 16'h0010
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [REG_AW-1:0]             addr,
  input  logic [MODE_W+LEN_W-1:0]       wdata,
  input  logic                          ev_cpu,
  input  logic                          ev_mgmt,
  input  logic [CNT_W-1:0]              count,
  output wd_mode_e                      mode,
  output wd_mode_e                      wr_mode,
  output logic [LEN_W-1:0]              len,
  output logic [1:0]                    pend,
  output logic [1:0]                    en,
  output logic                          ctrl_wr,
  output logic                          poke,
  output logic [MODE_W+LEN_W+CNT_W-1:0] rdata
);

  wd_mode_e         mode_q, mode_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [1:0]       pend_q, pend_d;
  logic [1:0]       en_q, en_d;
  logic             sel_pend, sel_set, sel_clr;

  assign ctrl_wr  = wr && (addr == RA_CTRL);
  assign sel_pend = wr && (addr == RA_PEND);
  assign sel_set  = wr && (addr == RA_ENSET);
  assign sel_clr  = wr && (addr == RA_ENCLR);
  assign poke     = wr && (addr == RA_POKE) && wdata[0];
  assign wr_mode  = wd_mode_e'(wdata[MODE_W-1:0]);

  always_comb begin
    mode_d    = ctrl_wr ? wr_mode : mode_q;
    len_d     = ctrl_wr ? wdata[MODE_W +: LEN_W] : len_q;
    pend_d[0] = ev_cpu  || (pend_q[0] && !(sel_pend && wdata[0]));
    pend_d[1] = ev_mgmt || (pend_q[1] && !(sel_pend && wdata[1]));
    en_d      = (en_q | ({2{sel_set}} & wdata[1:0])) & ~({2{sel_clr}} & wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WD_OFF;
      len_q  <= RST_LEN;
      pend_q <= 2'b00;
      en_q   <= 2'b00;
    end else begin
      mode_q <= mode_d;
      len_q  <= len_d;
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[MODE_W-1:0]              = mode_q;
        rdata[MODE_W +: LEN_W]         = len_q;
        rdata[MODE_W+LEN_W +: CNT_W]   = count;
      end
      RA_PEND:            rdata[1:0] = pend_q;
      RA_ENSET, RA_ENCLR: rdata[1:0] = en_q;
      default: ;
    endcase
  end

  assign mode = mode_q;
  assign len  = len_q;
  assign pend = pend_q;
  assign en   = en_q;

  // R9: a write-1 clear removes the CPU pending bit when no expiry sets it
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pend && wdata[0] && !ev_cpu) |=> !pend_q[0]);

  // R9: an expiry always leaves its pending bit set
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cpu |=> pend_q[0]);

endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import esc_wdog_pkg::*;
#(
  parameter int unsigned      PRESC_W = 10,
  parameter int unsigned      CNT_W   = 24,
  parameter int unsigned      LEN_W   = 16,
  parameter logic [LEN_W-1:0] RST_LEN = 16'h0010
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [MODE_W+LEN_W-1:0]       reg_wdata,
  output logic [MODE_W+LEN_W+CNT_W-1:0] reg_rdata,
  output logic                          cpu_irq,
  output logic                          mgmt_irq,
  output logic                          rst_req
);

  logic             srst_n;
  wd_mode_e         mode, wr_mode;
  logic [LEN_W-1:0] len;
  logic [1:0]       pend, en;
  logic             ctrl_wr, poke, run, tick, presc_clr;
  logic [CNT_W-1:0] count;
  wd_evt_t          evt;
  logic             rst_q, rst_d;

  esc_wdog_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  esc_wdog_regs #(
    .CNT_W   (CNT_W),
    .LEN_W   (LEN_W),
    .RST_LEN (RST_LEN)
  ) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .ev_cpu  (evt.cpu),
    .ev_mgmt (evt.mgmt),
    .count   (count),
    .mode    (mode),
    .wr_mode (wr_mode),
    .len     (len),
    .pend    (pend),
    .en      (en),
    .ctrl_wr (ctrl_wr),
    .poke    (poke),
    .rdata   (reg_rdata)
  );

  assign presc_clr = poke || (ctrl_wr && (wr_mode == WD_OFF));

  esc_wdog_presc #(
    .PRESC_W (PRESC_W)
  ) u_presc (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (run),
    .clr   (presc_clr),
    .tick  (tick)
  );

  esc_wdog_timer #(
    .CNT_W   (CNT_W),
    .LEN_W   (LEN_W),
    .RST_LEN (RST_LEN)
  ) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .tick    (tick),
    .poke    (poke),
    .ctrl_wr (ctrl_wr),
    .wr_mode (wr_mode),
    .mode    (mode),
    .len     (len),
    .count   (count),
    .run     (run),
    .evt     (evt)
  );

  assign rst_d = evt.rst;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rst_q <= 1'b0;
    else         rst_q <= rst_d;
  end

  assign rst_req  = rst_q;
  assign cpu_irq  = pend[0] && en[0];
  assign mgmt_irq = pend[1] && en[1];

  // R8: the reset request lasts a single cycle
  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |=> !rst_req);

  // R8: only the heaviest mode can request a reset
  assert_rst_mode_R8: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> ($past(mode) == WD_RESET));

endmodule

// File: tb/sim_esc_wdog.sv
module sim_esc_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 2;
  localparam int CW = 10;
  localparam int LW = 8;

  localparam logic [2:0] A_CTRL = 3'd0, A_PEND = 3'd1, A_SET = 3'd2, A_CLR = 3'd3, A_POKE = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [LW+1:0] reg_wdata = '0;
  logic [CW+LW+1:0] reg_rdata;
  logic cpu_irq, mgmt_irq, rst_req;

  logic wr1 = 1'b0;
  logic [2:0] addr1 = 3'd0;
  logic [17:0] wdata1 = '0;
  logic [41:0] rdata1;
  logic cpu1, mgmt1, rst1;

  int n_tests = 0;
  int n_fail = 0;
  int rst_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_wdog #(.PRESC_W(PW), .CNT_W(CW), .LEN_W(LW), .RST_LEN(8'h01)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .mgmt_irq(mgmt_irq), .rst_req(rst_req));

  esc_wdog u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr1), .reg_addr(addr1),
    .reg_wdata(wdata1), .reg_rdata(rdata1),
    .cpu_irq(cpu1), .mgmt_irq(mgmt1), .rst_req(rst1));

  always @(posedge clk) if (rst_req) rst_pulses <= rst_pulses + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [LW+1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW+LW+1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic int cnt_of(input logic [CW+LW+1:0] v);
    return int'(v[CW+LW+1:LW+2]);
  endfunction

  task automatic rd_cnt(output int c);
    logic [CW+LW+1:0] v;
    rd(A_CTRL, v);
    c = cnt_of(v);
  endtask

  task automatic rd_pend(output int p);
    logic [CW+LW+1:0] v;
    rd(A_PEND, v);
    p = int'(v[1:0]);
  endtask

  task automatic arm(input logic [1:0] m, input logic [7:0] l, input logic [1:0] e);
    wr(A_CTRL, '0);
    wr(A_PEND, 10'd3);
    wr(A_CLR, 10'd3);
    if (e != 2'b00) wr(A_SET, {8'h00, e});
    wr(A_CTRL, {l, m});
    wr(A_POKE, 10'd1);
  endtask

  task automatic t_reset;
    logic [CW+LW+1:0] v;
    rd(A_CTRL, v);
    chk("R1 mode", int'(v[1:0]), 0);
    chk("R1 len", int'(v[LW+1:2]), 1);
    chk("R1 count", cnt_of(v), 4);
    rd(A_PEND, v); chk("R1 pend", int'(v[1:0]), 0);
    rd(A_SET, v);  chk("R1 en", int'(v[1:0]), 0);
    chk("R1 outputs", int'({cpu_irq, mgmt_irq, rst_req}), 0);
  endtask

  task automatic t_stopped;
    int c, p;
    idle(50);
    rd_cnt(c); chk("R2 count held", c, 4);
    rd_pend(p); chk("R2 no expiry", p, 0);
  endtask

  task automatic t_prescale;
    addr1 = 3'd0; wdata1 = {16'h0010, 2'b01}; wr1 = 1'b1;
    @(negedge clk);
    wr1 = 1'b0;
    idle(1000);
    addr1 = A_CTRL; #1;
    chk("R3 before tick", int'(rdata1[41:18]), 4096);
    idle(30);
    addr1 = A_CTRL; #1;
    chk("R3 one step", int'(rdata1[41:18]), 4095);
  endtask

  task automatic t_poke;
    int c, p;
    arm(2'd1, 8'd1, 2'b00);
    rd_cnt(c); chk("R4 load", c, 4);
    idle(9);
    wr(A_POKE, 10'd0);
    idle(8);
    rd_pend(p); chk("R4 before expiry", p, 0);
    idle(2);
    rd_pend(p); chk("R4 zero poke ignored", p, 1);
    wr(A_PEND, 10'd1);
    wr(A_POKE, 10'd1);
    idle(19);
    rd_pend(p); chk("R4 poke restarts prescaler", p, 0);
    idle(1);
    rd_pend(p); chk("R4 expiry after poke", p, 1);
  endtask

  task automatic t_len_later;
    int c, p;
    arm(2'd1, 8'd1, 2'b00);
    wr(A_CTRL, {8'd2, 2'd1});
    rd_cnt(c); chk("R5 count untouched", c, 4);
    idle(18);
    rd_cnt(c); chk("R5 count at zero", c, 0);
    rd_pend(p); chk("R5 no early expiry", p, 0);
    idle(1);
    rd_cnt(c); chk("R5 reload uses new length", c, 8);
    rd_pend(p); chk("R5 expiry", p, 1);
  endtask

  task automatic t_mode1;
    int p;
    arm(2'd1, 8'd1, 2'b00);
    idle(20);
    rd_pend(p); chk("R6 first expiry", p, 1);
    chk("R10 gated off", int'(cpu_irq), 0);
    wr(A_PEND, 10'd1);
    idle(18);
    rd_pend(p); chk("R6 cleared", p, 0);
    idle(1);
    rd_pend(p); chk("R6 second expiry cpu again", p, 1);
  endtask

  task automatic t_mode2;
    int p;
    arm(2'd2, 8'd1, 2'b00);
    idle(20);
    rd_pend(p); chk("R7 first cpu", p, 1);
    idle(20);
    rd_pend(p); chk("R7 second mgmt", p, 3);
    wr(A_PEND, 10'd2);
    idle(18);
    rd_pend(p); chk("R7 mgmt cleared", p, 1);
    idle(1);
    rd_pend(p); chk("R7 third mgmt", p, 3);
  endtask

  task automatic t_mode3;
    int c, base;
    base = rst_pulses;
    arm(2'd3, 8'd1, 2'b11);
    idle(20);
    chk("R8 stage1 cpu_irq", int'(cpu_irq), 1);
    chk("R8 stage1 mgmt_irq", int'(mgmt_irq), 0);
    idle(20);
    chk("R8 stage2 mgmt_irq", int'(mgmt_irq), 1);
    idle(19);
    chk("R8 no early reset", int'(rst_req), 0);
    idle(1);
    chk("R8 reset pulse", int'(rst_req), 1);
    idle(1);
    chk("R8 pulse ends", int'(rst_req), 0);
    idle(60);
    rd_cnt(c); chk("R8 frozen count", c, 4);
    chk("R8 single pulse", rst_pulses - base, 1);
    wr(A_CTRL, {8'd1, 2'd3});
    idle(30);
    chk("R8 release restarts at stage one", rst_pulses - base, 1);
    rd_cnt(c);
    if (c == 4) chk("R8 released count moves", c, 3);
    wr(A_CTRL, '0);
  endtask

  task automatic t_nomgmt;
    int p;
    arm(2'd3, 8'd1, 2'b01);
    idle(40);
    rd_pend(p); chk("R10 pend after two expiries", p, 3);
    chk("R10 mgmt hidden", int'(mgmt_irq), 0);
    chk("R10 cpu shown", int'(cpu_irq), 1);
    wr(A_CLR, 10'd1);
    chk("R10 cpu enable cleared", int'(cpu_irq), 0);
    wr(A_SET, 10'd2);
    chk("R10 mgmt enable set", int'(mgmt_irq), 1);
    wr(A_CTRL, '0);
  endtask

  task automatic t_w1c;
    int p;
    arm(2'd1, 8'd1, 2'b00);
    idle(20);
    wr(A_PEND, 10'd0);
    rd_pend(p); chk("R9 write zero keeps", p, 1);
    wr(A_PEND, 10'd1);
    rd_pend(p); chk("R9 write one clears", p, 0);
    idle(17);
    wr(A_PEND, 10'd1);
    rd_pend(p); chk("R9 set wins over clear", p, 1);
  endtask

  task automatic t_collide;
    int c, p;
    arm(2'd1, 8'd1, 2'b00);
    idle(19);
    wr(A_POKE, 10'd1);
    rd_pend(p); chk("R12 poke beats expiry", p, 0);
    rd_cnt(c); chk("R12 count reloaded", c, 4);
  endtask

  task automatic t_mode0;
    int p;
    arm(2'd3, 8'd1, 2'b00);
    idle(20);
    wr(A_PEND, 10'd1);
    wr(A_CTRL, {8'd1, 2'd0});
    wr(A_CTRL, {8'd1, 2'd3});
    idle(19);
    rd_pend(p); chk("R11 prescaler cleared", p, 0);
    idle(1);
    rd_pend(p); chk("R11 stage cleared", p, 1);
    wr(A_CTRL, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_stopped;
    t_prescale;
    t_poke;
    t_len_later;
    t_mode1;
    t_mode2;
    t_mode3;
    t_nomgmt;
    t_w1c;
    t_collide;
    t_mode0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule